// File: doc/BRIEF.md
# Circular Reorder Buffer with Rollback

This block is the instruction window of an out-of-order core. Rename hands it decoded instructions in program order. Each one takes the slot at the tail of a circular buffer, and the slot number goes back to rename as the instruction's window tag. Functional units report completion by slot number, together with a fault code. The block retires instructions from the head strictly in program order. For each retired instruction it presents the opcode tag, the new destination physical tag and the displaced physical mapping, which architectural state uses to update itself and to free the old register.

Recovery comes in two forms:
- **Branch mispredict.** The branch unit names the slot of the mispredicted branch. Every younger slot is discarded and the tail moves back to just past the branch. Older work, including other branches still waiting to resolve, is kept.
- **Fault.** When the head instruction has finished with a nonzero fault code, the block signals an exception instead of retiring it. The tail then collapses onto the head, which empties the window.

Top module: `rob_window`

## Requirements
- R1: After reset the window is empty: `rob_empty`=1, `alloc_ready`=1, `alloc_idx`=0, and neither `cmt_valid` nor `exc_valid` is asserted.
- R2: An accepted allocation (`alloc_valid` and `alloc_ready` both high at a clock edge) writes the slot shown on `alloc_idx`. After the edge, `alloc_idx` has advanced by one modulo DEPTH, so slot DEPTH-1 is followed by slot 0.
- R3: Once DEPTH entries are live, `alloc_ready` is 0 and an `alloc_valid` request changes no slot. The window never holds more than DEPTH entries.
- R4: An entry retires only when it is the oldest live entry and it has been reported complete. Completions that arrive out of order still retire in allocation order. An empty window asserts neither `cmt_valid` nor `exc_valid`.
- R5: `cmt_valid` is asserted in the cycle after the completion of the oldest entry is registered. While it is high, `cmt_idx`, `cmt_op`, `cmt_pdst` and `cmt_pold` carry that entry's slot and the values stored at allocation. At most one entry retires per cycle.
- R6: If the oldest entry completed with a nonzero `cmpl_cause`, the block asserts `exc_valid` with `exc_idx` and `exc_cause` equal to that slot and code. It does not assert `cmt_valid`, and `alloc_ready` is 0. After the next edge the window is empty and `alloc_idx` equals the faulting slot.
- R7: A mispredict (`mis_valid`) on a live slot B discards every entry younger than B. After the edge, `alloc_idx` is B+1 modulo DEPTH. The discarded entries never retire.
- R8: Several branches may be outstanding, and they may resolve in any order. A mispredict on an older branch also removes a younger one that already rolled back the window.
- R9: A completion that names a slot that is not live (never allocated, or discarded) is ignored. A slot that is later reallocated starts out not complete.
- R10: A mispredict and a retirement in the same cycle both take effect. While `mis_valid` is high, `alloc_ready` is 0, so the rollback wins over allocation.
- R11: A mispredict that names a slot that is not live leaves the tail, and so `alloc_idx`, unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | Rename offers an instruction |
| alloc_op | input | OP_W | Opcode tag to store |
| alloc_pdst | input | PTAG_W | Newly assigned destination physical tag |
| alloc_pold | input | PTAG_W | Physical tag previously mapped to the destination |
| alloc_ready | output | 1 | Window accepts an allocation this cycle |
| alloc_idx | output | IDX_W | Slot the next allocation takes |
| cmpl_valid | input | 1 | Functional unit reports completion |
| cmpl_idx | input | IDX_W | Slot of the completed instruction |
| cmpl_cause | input | CAUSE_W | Fault code, zero when none |
| mis_valid | input | 1 | Branch resolved as mispredicted |
| mis_idx | input | IDX_W | Slot of the mispredicted branch |
| cmt_valid | output | 1 | Oldest entry retires this cycle |
| cmt_idx | output | IDX_W | Slot of the retiring entry |
| cmt_op | output | OP_W | Opcode tag of the retiring entry |
| cmt_pdst | output | PTAG_W | Destination physical tag of the retiring entry |
| cmt_pold | output | PTAG_W | Displaced physical tag of the retiring entry |
| exc_valid | output | 1 | Oldest entry faulted; window is being flushed |
| exc_idx | output | IDX_W | Slot of the faulting entry |
| exc_cause | output | CAUSE_W | Fault code of the faulting entry |
| rob_empty | output | 1 | No live entries |

## Verification
Every input change is registered at one edge, and the outputs are decoded from the registered state without further delay. So a completion of the oldest entry shows up as `cmt_valid` or `exc_valid` one cycle later, and a mispredict or fault shows up in `alloc_idx` and `rob_empty` one cycle later. The only output that responds within the same cycle is `alloc_ready`, which drops as soon as `mis_valid` is high. The bench drives inputs one time unit after a rising edge and reads outputs one unit later. In that way each check sees the state left by exactly the preceding edge. Slot numbers are predicted with modulo-DEPTH arithmetic from a running head count kept in the bench. The bursts of allocations sweep every slot and wrap the pointers several times.

// File: rtl/rob_pkg.sv
package rob_pkg;

  // Decoded condition of the oldest slot in the window.
  typedef enum logic [1:0] {
    HD_EMPTY  = 2'd0,
    HD_WAIT   = 2'd1,
    HD_RETIRE = 2'd2,
    HD_FAULT  = 2'd3
  } head_state_e;

endpackage

// File: rtl/rob_ptr_ctrl.sv
module rob_ptr_ctrl #(
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_fire,
  input  logic             retire,
  input  logic             fault,
  input  logic             rollback,
  input  logic [IDX_W-1:0] rb_dist,
  output logic [IDX_W:0]   head_ptr,
  output logic [IDX_W:0]   tail_ptr
);

  logic [IDX_W:0] head_d, tail_d;
  logic           head_en, tail_en;

  // Next-state: fault collapses tail onto head, rollback rebuilds the tail
  // from the head so the wrap bit stays consistent, allocation bumps it.
  always_comb begin
    head_en = retire;
    head_d  = head_ptr + {{IDX_W{1'b0}}, 1'b1};
    tail_en = fault | rollback | alloc_fire;
    if (fault) begin
      tail_d = head_ptr;
    end else if (rollback) begin
      tail_d = head_ptr + {1'b0, rb_dist} + {{IDX_W{1'b0}}, 1'b1};
    end else begin
      tail_d = tail_ptr + {{IDX_W{1'b0}}, 1'b1};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_ptr <= '0;
      tail_ptr <= '0;
    end else begin
      if (head_en) head_ptr <= head_d;
      if (tail_en) tail_ptr <= tail_d;
    end
  end

endmodule

// File: rtl/rob_kill_mask.sv
module rob_kill_mask #(
  parameter int DEPTH = 8,
  parameter int IDX_W = 3
) (
  input  logic [IDX_W-1:0] head_idx,
  input  logic [IDX_W-1:0] mis_idx,
  input  logic             mis_ok,
  output logic [DEPTH-1:0] kill_vec,
  output logic [IDX_W-1:0] branch_age
);

  assign branch_age = mis_idx - head_idx;

  // A slot is younger than the branch when its distance from the head
  // exceeds the branch's distance; live slots never wrap past the head.
  for (genvar g = 0; g < DEPTH; g++) begin : g_age
    logic [IDX_W-1:0] slot_age;
    assign slot_age    = IDX_W'(g) - head_idx;
    assign kill_vec[g] = mis_ok && (slot_age > branch_age);
  end

endmodule

// File: rtl/rob_entry_store.sv
module rob_entry_store #(
  parameter int DEPTH   = 8,
  parameter int IDX_W   = 3,
  parameter int OP_W    = 4,
  parameter int PTAG_W  = 6,
  parameter int CAUSE_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               alloc_fire,
  input  logic [IDX_W-1:0]   alloc_slot,
  input  logic [OP_W-1:0]    alloc_op,
  input  logic [PTAG_W-1:0]  alloc_pdst,
  input  logic [PTAG_W-1:0]  alloc_pold,
  input  logic               cmpl_valid,
  input  logic [IDX_W-1:0]   cmpl_idx,
  input  logic [CAUSE_W-1:0] cmpl_cause,
  input  logic [DEPTH-1:0]   kill_vec,
  input  logic               flush_all,
  input  logic               retire,
  input  logic [IDX_W-1:0]   head_idx,
  output logic [DEPTH-1:0]   use_vec,
  output logic [DEPTH-1:0]   exec_vec,
  output logic [OP_W-1:0]    hd_op,
  output logic [PTAG_W-1:0]  hd_pdst,
  output logic [PTAG_W-1:0]  hd_pold,
  output logic [CAUSE_W-1:0] hd_cause
);

  logic [OP_W-1:0]    op_arr    [DEPTH];
  logic [PTAG_W-1:0]  pdst_arr  [DEPTH];
  logic [PTAG_W-1:0]  pold_arr  [DEPTH];
  logic [CAUSE_W-1:0] cause_arr [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic               alloc_hit, cmpl_hit, retire_hit;
    logic               use_q, use_d, exec_q, exec_d, flag_en;
    logic [CAUSE_W-1:0] cause_q, cause_d;
    logic [OP_W-1:0]    op_q;
    logic [PTAG_W-1:0]  pdst_q, pold_q;

    assign alloc_hit  = alloc_fire && (alloc_slot == IDX_W'(g));
    assign cmpl_hit   = cmpl_valid && (cmpl_idx == IDX_W'(g)) && use_q && !kill_vec[g];
    assign retire_hit = retire && (head_idx == IDX_W'(g));

    always_comb begin
      use_d   = use_q;
      exec_d  = exec_q;
      cause_d = cause_q;
      if (flush_all || kill_vec[g] || retire_hit) begin
        use_d  = 1'b0;
        exec_d = 1'b0;
      end else if (alloc_hit) begin
        use_d   = 1'b1;
        exec_d  = 1'b0;
        cause_d = '0;
      end else if (cmpl_hit) begin
        exec_d  = 1'b1;
        cause_d = cmpl_cause;
      end
      flag_en = flush_all | kill_vec[g] | retire_hit | alloc_hit | cmpl_hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        use_q   <= 1'b0;
        exec_q  <= 1'b0;
        cause_q <= '0;
      end else if (flag_en) begin
        use_q   <= use_d;
        exec_q  <= exec_d;
        cause_q <= cause_d;
      end
    end

    // Payload is meaningful only while the slot is live: no reset needed.
    always_ff @(posedge clk) begin
      if (alloc_hit) begin
        op_q   <= alloc_op;
        pdst_q <= alloc_pdst;
        pold_q <= alloc_pold;
      end
    end

    assign use_vec[g]   = use_q;
    assign exec_vec[g]  = exec_q;
    assign op_arr[g]    = op_q;
    assign pdst_arr[g]  = pdst_q;
    assign pold_arr[g]  = pold_q;
    assign cause_arr[g] = cause_q;
  end

  assign hd_op    = op_arr[head_idx];
  assign hd_pdst  = pdst_arr[head_idx];
  assign hd_pold  = pold_arr[head_idx];
  assign hd_cause = cause_arr[head_idx];

endmodule

// File: rtl/rob_window.sv
module rob_window #(
  parameter int DEPTH   = 8,
  parameter int OP_W    = 4,
  parameter int PTAG_W  = 6,
  parameter int CAUSE_W = 3,
  localparam int IDX_W  = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               alloc_valid,
  input  logic [OP_W-1:0]    alloc_op,
  input  logic [PTAG_W-1:0]  alloc_pdst,
  input  logic [PTAG_W-1:0]  alloc_pold,
  output logic               alloc_ready,
  output logic [IDX_W-1:0]   alloc_idx,
  input  logic               cmpl_valid,
  input  logic [IDX_W-1:0]   cmpl_idx,
  input  logic [CAUSE_W-1:0] cmpl_cause,
  input  logic               mis_valid,
  input  logic [IDX_W-1:0]   mis_idx,
  output logic               cmt_valid,
  output logic [IDX_W-1:0]   cmt_idx,
  output logic [OP_W-1:0]    cmt_op,
  output logic [PTAG_W-1:0]  cmt_pdst,
  output logic [PTAG_W-1:0]  cmt_pold,
  output logic               exc_valid,
  output logic [IDX_W-1:0]   exc_idx,
  output logic [CAUSE_W-1:0] exc_cause,
  output logic               rob_empty
);

  import rob_pkg::*;

  logic [IDX_W:0]     head_ptr, tail_ptr;
  logic [IDX_W-1:0]   head_idx, branch_age;
  logic [DEPTH-1:0]   use_vec, exec_vec, kill_vec;
  logic [OP_W-1:0]    hd_op;
  logic [PTAG_W-1:0]  hd_pdst, hd_pold;
  logic [CAUSE_W-1:0] hd_cause;
  logic               full, retire, fault, mis_ok, alloc_fire;
  head_state_e        hd_state;

  assign head_idx  = head_ptr[IDX_W-1:0];
  assign alloc_idx = tail_ptr[IDX_W-1:0];
  assign full      = (head_ptr ^ tail_ptr) == {1'b1, {IDX_W{1'b0}}};
  assign rob_empty = (head_ptr == tail_ptr);

  always_comb begin
    if (!use_vec[head_idx])       hd_state = HD_EMPTY;
    else if (!exec_vec[head_idx]) hd_state = HD_WAIT;
    else if (hd_cause != '0)      hd_state = HD_FAULT;
    else                          hd_state = HD_RETIRE;
  end

  assign retire      = (hd_state == HD_RETIRE);
  assign fault       = (hd_state == HD_FAULT);
  assign mis_ok      = mis_valid && use_vec[mis_idx] && !fault;
  assign alloc_ready = !full && !mis_valid && !fault;
  assign alloc_fire  = alloc_valid && alloc_ready;

  rob_ptr_ctrl #(.IDX_W(IDX_W)) u_ptr (
    .clk        (clk),
    .rst_n      (rst_n),
    .alloc_fire (alloc_fire),
    .retire     (retire),
    .fault      (fault),
    .rollback   (mis_ok),
    .rb_dist    (branch_age),
    .head_ptr   (head_ptr),
    .tail_ptr   (tail_ptr)
  );

  rob_kill_mask #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_kill (
    .head_idx   (head_idx),
    .mis_idx    (mis_idx),
    .mis_ok     (mis_ok),
    .kill_vec   (kill_vec),
    .branch_age (branch_age)
  );

  rob_entry_store #(
    .DEPTH(DEPTH), .IDX_W(IDX_W), .OP_W(OP_W), .PTAG_W(PTAG_W), .CAUSE_W(CAUSE_W)
  ) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .alloc_fire (alloc_fire),
    .alloc_slot (alloc_idx),
    .alloc_op   (alloc_op),
    .alloc_pdst (alloc_pdst),
    .alloc_pold (alloc_pold),
    .cmpl_valid (cmpl_valid),
    .cmpl_idx   (cmpl_idx),
    .cmpl_cause (cmpl_cause),
    .kill_vec   (kill_vec),
    .flush_all  (fault),
    .retire     (retire),
    .head_idx   (head_idx),
    .use_vec    (use_vec),
    .exec_vec   (exec_vec),
    .hd_op      (hd_op),
    .hd_pdst    (hd_pdst),
    .hd_pold    (hd_pold),
    .hd_cause   (hd_cause)
  );

  assign cmt_valid = retire;
  assign cmt_idx   = head_idx;
  assign cmt_op    = hd_op;
  assign cmt_pdst  = hd_pdst;
  assign cmt_pold  = hd_pold;
  assign exc_valid = fault;
  assign exc_idx   = head_idx;
  assign exc_cause = hd_cause;

endmodule

// File: rtl/rob_window_chk.sv
module rob_window_chk #(
  parameter int DEPTH = 8,
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             alloc_valid,
  input logic             alloc_ready,
  input logic [IDX_W-1:0] alloc_idx,
  input logic             mis_valid,
  input logic [IDX_W-1:0] mis_idx,
  input logic             cmt_valid,
  input logic             exc_valid,
  input logic             rob_empty,
  input logic [IDX_W:0]   head_ptr,
  input logic [IDX_W:0]   tail_ptr,
  input logic [DEPTH-1:0] use_vec
);

  logic [IDX_W:0] live_cnt;
  assign live_cnt = tail_ptr - head_ptr;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    live_cnt <= (IDX_W+1)'(DEPTH)); // R3

  AST_ALLOC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && alloc_ready) |=> alloc_idx == IDX_W'($past(alloc_idx) + 1'b1)); // R2

  AST_EMPTY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    rob_empty |-> (!cmt_valid && !exc_valid)); // R4

  AST_RETIRE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    cmt_valid |=> head_ptr == (IDX_W+1)'($past(head_ptr) + 1'b1)); // R5

  AST_FAULT_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |=> rob_empty); // R6

  AST_ROLLBACK_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
    (mis_valid && use_vec[mis_idx] && !exc_valid) |=> alloc_idx == IDX_W'($past(mis_idx) + 1'b1)); // R7

  AST_DEAD_BRANCH: assert property (@(posedge clk) disable iff (!rst_n)
    (mis_valid && !use_vec[mis_idx] && !exc_valid) |=> $stable(tail_ptr)); // R11

endmodule

bind rob_window rob_window_chk #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .alloc_valid (alloc_valid),
  .alloc_ready (alloc_ready),
  .alloc_idx   (alloc_idx),
  .mis_valid   (mis_valid),
  .mis_idx     (mis_idx),
  .cmt_valid   (cmt_valid),
  .exc_valid   (exc_valid),
  .rob_empty   (rob_empty),
  .head_ptr    (head_ptr),
  .tail_ptr    (tail_ptr),
  .use_vec     (use_vec)
);

// File: tb/sim_rob_window.sv
module sim_rob_window;

  localparam int DEPTH = 8;
  localparam int IW    = 3;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       alloc_valid, cmpl_valid, mis_valid;
  logic [3:0] alloc_op;
  logic [5:0] alloc_pdst, alloc_pold;
  logic [2:0] cmpl_idx, cmpl_cause, mis_idx;
  logic       alloc_ready, cmt_valid, exc_valid, rob_empty;
  logic [2:0] alloc_idx, cmt_idx, exc_idx, exc_cause;
  logic [3:0] cmt_op;
  logic [5:0] cmt_pdst, cmt_pold;

  int n_chk = 0;
  int n_fail = 0;
  int hd = 0;
  bit done = 0;

  always #2 clk = ~clk;

  rob_window u0 (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_op(alloc_op), .alloc_pdst(alloc_pdst),
    .alloc_pold(alloc_pold), .alloc_ready(alloc_ready), .alloc_idx(alloc_idx),
    .cmpl_valid(cmpl_valid), .cmpl_idx(cmpl_idx), .cmpl_cause(cmpl_cause),
    .mis_valid(mis_valid), .mis_idx(mis_idx),
    .cmt_valid(cmt_valid), .cmt_idx(cmt_idx), .cmt_op(cmt_op),
    .cmt_pdst(cmt_pdst), .cmt_pold(cmt_pold),
    .exc_valid(exc_valid), .exc_idx(exc_idx), .exc_cause(exc_cause),
    .rob_empty(rob_empty)
  );

  function automatic logic [2:0] sl(input int k);
    return 3'((hd + k) % DEPTH);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    alloc_valid = 0; cmpl_valid = 0; mis_valid = 0;
  endtask

  task automatic settle();
    #1;
  endtask

  task automatic alloc(input int tagv);
    alloc_valid = 1; alloc_op = 4'(tagv); alloc_pdst = 6'(tagv + 8); alloc_pold = 6'(tagv + 20);
  endtask

  task automatic cmpl(input logic [2:0] s, input logic [2:0] c);
    cmpl_valid = 1; cmpl_idx = s; cmpl_cause = c;
  endtask

  // Allocate n entries, complete them youngest first, expect in-order retirement.
  task automatic burst(input int n);
    for (int k = 0; k < n; k++) begin
      alloc(k);
      settle();
      chk("R2 alloc slot", alloc_idx, sl(k));
      tick();
    end
    if (n == DEPTH) begin
      alloc(15);
      settle();
      chk("R3 ready when full", alloc_ready, 0);
      tick();
    end
    for (int k = n - 1; k >= 1; k--) begin
      cmpl(sl(k), 0);
      settle();
      chk("R4 no early retire", cmt_valid, 0);
      tick();
    end
    cmpl(sl(0), 0);
    tick();
    for (int k = 0; k < n; k++) begin
      settle();
      chk("R5 retire valid", cmt_valid, 1);
      chk("R4 retire order", cmt_idx, sl(k));
      chk("R5 retire op", cmt_op, k);
      chk("R5 retire pdst", cmt_pdst, k + 8);
      chk("R5 retire pold", cmt_pold, k + 20);
      tick();
    end
    hd = (hd + n) % DEPTH;
    settle();
    chk("R4 empty after drain", rob_empty, 1);
    chk("R4 empty quiet", cmt_valid, 0);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; alloc_valid = 0; cmpl_valid = 0; mis_valid = 0;
    alloc_op = 0; alloc_pdst = 0; alloc_pold = 0;
    cmpl_idx = 0; cmpl_cause = 0; mis_idx = 0;
    #9;
    settle();
    chk("R1 empty", rob_empty, 1);
    chk("R1 ready", alloc_ready, 1);
    chk("R1 slot", alloc_idx, 0);
    chk("R1 no retire", cmt_valid, 0);
    chk("R1 no fault", exc_valid, 0);
    @(negedge clk); rst_n = 1;
    tick();

    // Sweep: full window, then bursts of every size to wrap the pointers
    burst(DEPTH);
    for (int n = 1; n <= DEPTH; n++) burst(n);

    // R9: stray completion on an empty slot, then reuse of that slot
    cmpl(sl(0), 0);
    tick();
    settle();
    chk("R9 stray completion", rob_empty, 1);
    alloc(3);
    tick();
    settle();
    chk("R9 fresh slot not complete", cmt_valid, 0);
    cmpl(sl(0), 0);
    tick();
    settle();
    chk("R9 retire after real completion", cmt_valid, 1);
    tick();
    hd = (hd + 1) % DEPTH;

    // R6: fault at the head flushes everything
    for (int k = 0; k < 4; k++) begin alloc(k); tick(); end
    cmpl(sl(1), 0);
    tick();
    cmpl(sl(0), 5);
    tick();
    settle();
    chk("R6 fault flag", exc_valid, 1);
    chk("R6 fault code", exc_cause, 5);
    chk("R6 fault slot", exc_idx, sl(0));
    chk("R6 no retire", cmt_valid, 0);
    chk("R6 alloc refused", alloc_ready, 0);
    tick();
    settle();
    chk("R6 empty after flush", rob_empty, 1);
    chk("R6 tail at head", alloc_idx, sl(0));

    // R7: mispredict kills younger entries
    for (int k = 0; k < 6; k++) begin alloc(k); tick(); end
    mis_valid = 1; mis_idx = sl(2);
    settle();
    chk("R10 ready low in rollback", alloc_ready, 0);
    tick();
    settle();
    chk("R7 tail past branch", alloc_idx, sl(3));
    cmpl(sl(4), 0);
    tick();
    cmpl(sl(2), 0); tick();
    cmpl(sl(1), 0); tick();
    cmpl(sl(0), 0); tick();
    for (int k = 0; k < 3; k++) begin
      settle();
      chk("R7 survivor retires", cmt_idx, sl(k));
      tick();
    end
    settle();
    chk("R7 killed never retire", rob_empty, 1);
    chk("R9 killed completion ignored", cmt_valid, 0);
    hd = (hd + 3) % DEPTH;

    // R8 and R11: two branches resolved youngest first, then a dead one
    for (int k = 0; k < 6; k++) begin alloc(k); tick(); end
    mis_valid = 1; mis_idx = sl(3);
    tick();
    settle();
    chk("R8 young branch rollback", alloc_idx, sl(4));
    mis_valid = 1; mis_idx = sl(1);
    tick();
    settle();
    chk("R8 older branch rollback", alloc_idx, sl(2));
    mis_valid = 1; mis_idx = sl(3);
    tick();
    settle();
    chk("R11 dead branch ignored", alloc_idx, sl(2));
    cmpl(sl(1), 0); tick();
    cmpl(sl(0), 0); tick();
    settle(); chk("R8 retire oldest", cmt_idx, sl(0)); tick();
    settle(); chk("R8 retire branch", cmt_idx, sl(1)); tick();
    settle();
    chk("R8 drained", rob_empty, 1);
    hd = (hd + 2) % DEPTH;

    // R10: mispredict concurrent with retirement of the head
    for (int k = 0; k < 3; k++) begin alloc(k); tick(); end
    cmpl(sl(0), 0);
    tick();
    mis_valid = 1; mis_idx = sl(1);
    settle();
    chk("R10 retire during rollback", cmt_valid, 1);
    chk("R10 rollback blocks alloc", alloc_ready, 0);
    tick();
    settle();
    chk("R10 tail after rollback", alloc_idx, sl(2));
    chk("R10 branch still live", rob_empty, 0);
    chk("R10 head advanced", cmt_valid, 0);
    cmpl(sl(1), 0);
    tick();
    settle();
    chk("R10 branch retires", cmt_idx, sl(1));
    tick();
    settle();
    chk("R10 drained", rob_empty, 1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule